// File: doc/BRIEF.md
# Link-Side Inter-Packet Gap Controller for a ULPI USB Link

This block lives in the link half of a ULPI USB connection. It decides when the link may drive a transmit command after an earlier packet. It watches the bus direction, the stop strobe and the link's own transmit start, together with the decoded fields of each receive command (the line state and the receive-active flag). A speed input selects high, full or low speed, and a role input marks the link as host or peripheral. The block counts link clock cycles from the event that closes the previous packet and opens a transmit window for the link. The event and the window both depend on the kind of packet sequence and on the bus speed.

The link raises a send request and holds it. The block answers with a transmit-allowed gate, which the link uses to time its command. The block also raises a one-cycle response-timeout pulse when a transmitted packet gets no answer. A one-cycle window-missed pulse marks a pending request that let the window close without the link transmitting. All window limits are constant parameters, with one set for each speed.

Top module: `ulpi_gap_ctrl`

## Requirements
- R1: After synchronous reset the block is idle: `tx_allow` is high, and `resp_timeout` and `window_miss` are low.
- R2: A transmit starts on a cycle with `tx_go` high. In high speed, the transmit ends on a cycle with `stp` high and `dir` low. The host may then transmit again from the 15th to the 24th cycle counted from that end cycle (the end cycle is cycle 0). At full speed the host window is 7 to 18 cycles, and at low speed it is 77 to 247 cycles. In peripheral role `tx_allow` stays low for the whole wait.
- R3: At full and low speed, counting for both transmit-then-transmit and receive-then-transmit starts at a receive command whose line state is J while the previous receive command showed SE0. Line state encoding: 00 = SE0, J = 01 at full speed and 10 at low speed. A J code that belongs to the other speed does not start the count.
- R4: After a received packet the link may transmit from cycle 1 to 14 in high speed, 7 to 18 at full speed and 77 to 247 at low speed. In high speed the packet ends when `dir` goes low or when a receive command shows `rx_active` low. When the window closes the block returns to idle.
- R5: A receive starts on a cycle with `dir`, `rxcmd_valid` and `rx_active` all high. It is accepted in any waiting state, including one cycle after the previous receive ended. `tx_allow` stays low while the receive lasts.
- R6: If no response arrives after a transmit, `resp_timeout` pulses for one cycle at cycle 92 (high), 80 (full) or 718 (low). `tx_allow` is high from the next cycle on.
- R7: A receive that starts during the wait after a transmit cancels the timeout. `resp_timeout` does not pulse for that transmit.
- R8: `window_miss` pulses in the cycle at the upper window limit when `send_req` is high and `tx_go` is low. It applies to the host transmit-then-transmit window and to the receive-then-transmit window.
- R9: Speed encoding: 00 = high, 01 = full, 10 = low, and 11 is treated as high. A change of `speed` takes effect only while the block is idle.
- R10: After a `tx_go` outside a receive, `tx_allow` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| speed | input | 2 | Bus speed selection (00 high, 01 full, 10 low) |
| host_role | input | 1 | 1 = host, 0 = peripheral |
| dir | input | 1 | Bus direction, high when the transceiver drives the bus |
| stp | input | 1 | Stop strobe that ends a link transmit |
| tx_go | input | 1 | Link drives a transmit command in this cycle |
| send_req | input | 1 | Link holds a pending send request |
| rxcmd_valid | input | 1 | A decoded receive command is present |
| rx_linestate | input | 2 | Line state field of the receive command |
| rx_active | input | 1 | Receive-active field of the receive command |
| tx_allow | output | 1 | Link may start a transmit command |
| resp_timeout | output | 1 | One-cycle pulse: no response arrived in time |
| window_miss | output | 1 | One-cycle pulse: a pending request let the window close |

## Verification
A wrong cycle count or a wrong state shows up at once on `tx_allow`: the gate opens or closes one cycle away from the limit for that speed. The sweeps check the gate in every cycle of every window, so an off-by-one error fails in the first cycle where it applies. A wrong trigger event, such as the wrong J code, the wrong end-of-receive condition or a live speed input, leaves the gate closed or sets the wrong window length. This shows within a few cycles of the trigger. A lost timeout cancel shows as a stray `resp_timeout` pulse at the timeout count.

// File: rtl/gapc_pkg.sv
package gapc_pkg;

    parameter int GAP_CNT_W = 10;

    localparam logic [1:0] SPD_HS = 2'b00;
    localparam logic [1:0] SPD_FS = 2'b01;
    localparam logic [1:0] SPD_LS = 2'b10;

    localparam logic [1:0] LINE_SE0  = 2'b00;
    localparam logic [1:0] LINE_FS_J = 2'b01;
    localparam logic [1:0] LINE_LS_J = 2'b10;
    localparam logic [1:0] LINE_SE1  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_TX_ARM,
        ST_TX_WAIT,
        ST_RX,
        ST_RX_WAIT
    } gap_state_e;

    typedef struct packed {
        logic [GAP_CNT_W-1:0] tt_min;
        logic [GAP_CNT_W-1:0] tt_max;
        logic [GAP_CNT_W-1:0] rt_min;
        logic [GAP_CNT_W-1:0] rt_max;
        logic [GAP_CNT_W-1:0] to_lim;
    } gap_win_t;

    function automatic logic spd_is_hs(input logic [1:0] s);
        return !(s == SPD_FS || s == SPD_LS);
    endfunction

    function automatic logic [1:0] idle_j(input logic [1:0] s);
        return (s == SPD_LS) ? LINE_LS_J : LINE_FS_J;
    endfunction

endpackage

// File: rtl/gapc_evt_decode.sv
module gapc_evt_decode
    import gapc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] spd,
    input  logic       dir,
    input  logic       rxcmd_valid,
    input  logic [1:0] linestate,
    input  logic       rx_active,
    output logic       se0_to_j,
    output logic       rx_start,
    output logic       rx_stop_hs
);

    logic [1:0] line_prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            line_prev_q <= LINE_SE1;
        else if (rxcmd_valid)
            line_prev_q <= linestate;
    end

    always_comb begin
        se0_to_j   = rxcmd_valid && (line_prev_q == LINE_SE0) && (linestate == idle_j(spd));
        rx_start   = dir && rxcmd_valid && rx_active;
        rx_stop_hs = !dir || (rxcmd_valid && !rx_active);
    end

endmodule

// File: rtl/gapc_win_sel.sv
module gapc_win_sel
    import gapc_pkg::*;
#(
    parameter int HS_TT_MIN = 15,
    parameter int HS_TT_MAX = 24,
    parameter int FS_TT_MIN = 7,
    parameter int FS_TT_MAX = 18,
    parameter int LS_TT_MIN = 77,
    parameter int LS_TT_MAX = 247,
    parameter int HS_RT_MIN = 1,
    parameter int HS_RT_MAX = 14,
    parameter int FS_RT_MIN = 7,
    parameter int FS_RT_MAX = 18,
    parameter int LS_RT_MIN = 77,
    parameter int LS_RT_MAX = 247,
    parameter int HS_TO     = 92,
    parameter int FS_TO     = 80,
    parameter int LS_TO     = 718
) (
    input  logic [1:0] spd,
    output gap_win_t   win
);

    localparam gap_win_t HS_W = '{
        tt_min: GAP_CNT_W'(HS_TT_MIN), tt_max: GAP_CNT_W'(HS_TT_MAX),
        rt_min: GAP_CNT_W'(HS_RT_MIN), rt_max: GAP_CNT_W'(HS_RT_MAX),
        to_lim: GAP_CNT_W'(HS_TO)};
    localparam gap_win_t FS_W = '{
        tt_min: GAP_CNT_W'(FS_TT_MIN), tt_max: GAP_CNT_W'(FS_TT_MAX),
        rt_min: GAP_CNT_W'(FS_RT_MIN), rt_max: GAP_CNT_W'(FS_RT_MAX),
        to_lim: GAP_CNT_W'(FS_TO)};
    localparam gap_win_t LS_W = '{
        tt_min: GAP_CNT_W'(LS_TT_MIN), tt_max: GAP_CNT_W'(LS_TT_MAX),
        rt_min: GAP_CNT_W'(LS_RT_MIN), rt_max: GAP_CNT_W'(LS_RT_MAX),
        to_lim: GAP_CNT_W'(LS_TO)};

    always_comb begin
        case (spd)
            SPD_FS:  win = FS_W;
            SPD_LS:  win = LS_W;
            default: win = HS_W;
        endcase
    end

endmodule

// File: rtl/gapc_seq_fsm.sv
module gapc_seq_fsm
    import gapc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_in,
    input  logic       host_role,
    input  logic       stp,
    input  logic       dir,
    input  logic       tx_go,
    input  logic       send_req,
    input  logic       se0_to_j,
    input  logic       rx_start,
    input  logic       rx_stop_hs,
    input  gap_win_t   win,
    output logic [1:0] spd_q,
    output gap_state_e st,
    output logic       tx_allow,
    output logic       resp_timeout,
    output logic       window_miss
);

    localparam logic [GAP_CNT_W-1:0] CNT_ONE = GAP_CNT_W'(1);

    gap_state_e           st_q, st_d;
    logic [GAP_CNT_W-1:0] cnt_q, cnt_d;
    logic                 hs, rx_done, in_tt, in_rt;

    assign hs      = spd_is_hs(spd_q);
    assign rx_done = hs ? rx_stop_hs : se0_to_j;
    assign st      = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            spd_q <= SPD_HS;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == ST_IDLE)
                spd_q <= speed_in;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_IDLE: begin
                if (rx_start)   st_d = ST_RX;
                else if (tx_go) st_d = ST_TX;
            end
            ST_TX: begin
                if (stp && !dir) begin
                    st_d  = hs ? ST_TX_WAIT : ST_TX_ARM;
                    cnt_d = CNT_ONE;
                end
            end
            ST_TX_ARM: begin
                if (rx_start) st_d = ST_RX;
                else if (se0_to_j) begin
                    st_d  = ST_TX_WAIT;
                    cnt_d = CNT_ONE;
                end
            end
            ST_TX_WAIT: begin
                if (rx_start)                 st_d = ST_RX;
                else if (tx_go)               st_d = ST_TX;
                else if (cnt_q >= win.to_lim) st_d = ST_IDLE;
                else                          cnt_d = cnt_q + CNT_ONE;
            end
            ST_RX: begin
                if (rx_done) begin
                    st_d  = ST_RX_WAIT;
                    cnt_d = CNT_ONE;
                end
            end
            ST_RX_WAIT: begin
                if (rx_start)                 st_d = ST_RX;
                else if (tx_go)               st_d = ST_TX;
                else if (cnt_q >= win.rt_max) st_d = ST_IDLE;
                else                          cnt_d = cnt_q + CNT_ONE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_tt = (cnt_q >= win.tt_min) && (cnt_q <= win.tt_max);
        in_rt = (cnt_q >= win.rt_min) && (cnt_q <= win.rt_max);
        tx_allow = (st_q == ST_IDLE)
                || (st_q == ST_TX_WAIT && host_role && in_tt)
                || (st_q == ST_RX_WAIT && in_rt);
        resp_timeout = (st_q == ST_TX_WAIT) && (cnt_q == win.to_lim) && !rx_start;
        window_miss  = send_req && !tx_go && !rx_start &&
                       (((st_q == ST_TX_WAIT) && host_role && (cnt_q == win.tt_max)) ||
                        ((st_q == ST_RX_WAIT) && (cnt_q == win.rt_max)));
    end

endmodule

// File: rtl/ulpi_gap_ctrl.sv
module ulpi_gap_ctrl
    import gapc_pkg::*;
#(
    parameter int HS_TT_MIN = 15,
    parameter int HS_TT_MAX = 24,
    parameter int FS_TT_MIN = 7,
    parameter int FS_TT_MAX = 18,
    parameter int LS_TT_MIN = 77,
    parameter int LS_TT_MAX = 247,
    parameter int HS_RT_MIN = 1,
    parameter int HS_RT_MAX = 14,
    parameter int FS_RT_MIN = 7,
    parameter int FS_RT_MAX = 18,
    parameter int LS_RT_MIN = 77,
    parameter int LS_RT_MAX = 247,
    parameter int HS_TO     = 92,
    parameter int FS_TO     = 80,
    parameter int LS_TO     = 718
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed,
    input  logic       host_role,
    input  logic       dir,
    input  logic       stp,
    input  logic       tx_go,
    input  logic       send_req,
    input  logic       rxcmd_valid,
    input  logic [1:0] rx_linestate,
    input  logic       rx_active,
    output logic       tx_allow,
    output logic       resp_timeout,
    output logic       window_miss
);

    logic [1:0] spd_q;
    gap_state_e st;
    gap_win_t   win;
    logic       se0_to_j, rx_start, rx_stop_hs;

    gapc_evt_decode u_evt (
        .clk(clk), .rst(rst), .spd(spd_q), .dir(dir),
        .rxcmd_valid(rxcmd_valid), .linestate(rx_linestate), .rx_active(rx_active),
        .se0_to_j(se0_to_j), .rx_start(rx_start), .rx_stop_hs(rx_stop_hs)
    );

    gapc_win_sel #(
        .HS_TT_MIN(HS_TT_MIN), .HS_TT_MAX(HS_TT_MAX),
        .FS_TT_MIN(FS_TT_MIN), .FS_TT_MAX(FS_TT_MAX),
        .LS_TT_MIN(LS_TT_MIN), .LS_TT_MAX(LS_TT_MAX),
        .HS_RT_MIN(HS_RT_MIN), .HS_RT_MAX(HS_RT_MAX),
        .FS_RT_MIN(FS_RT_MIN), .FS_RT_MAX(FS_RT_MAX),
        .LS_RT_MIN(LS_RT_MIN), .LS_RT_MAX(LS_RT_MAX),
        .HS_TO(HS_TO), .FS_TO(FS_TO), .LS_TO(LS_TO)
    ) u_win (
        .spd(spd_q), .win(win)
    );

    gapc_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .speed_in(speed), .host_role(host_role),
        .stp(stp), .dir(dir), .tx_go(tx_go), .send_req(send_req),
        .se0_to_j(se0_to_j), .rx_start(rx_start), .rx_stop_hs(rx_stop_hs),
        .win(win), .spd_q(spd_q), .st(st),
        .tx_allow(tx_allow), .resp_timeout(resp_timeout), .window_miss(window_miss)
    );

endmodule

// File: rtl/ulpi_gap_ctrl_chk.sv
module ulpi_gap_ctrl_chk
    import gapc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dir,
    input logic       rxcmd_valid,
    input logic       rx_active,
    input logic       tx_go,
    input gap_state_e st,
    input logic [1:0] spd_q,
    input logic       tx_allow,
    input logic       resp_timeout,
    input logic       window_miss
);

    // R6
    timeout_reopens_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_timeout && !tx_go) |=> tx_allow);

    // R6
    timeout_gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(resp_timeout && tx_allow));

    // R8
    miss_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        window_miss |=> !window_miss);

    // R5
    rx_closes_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dir && rxcmd_valid && rx_active) |=> !tx_allow);

    // R10
    go_closes_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_go && st != ST_RX) |=> !tx_allow);

    // R9
    speed_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(spd_q));

endmodule

bind ulpi_gap_ctrl ulpi_gap_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .dir(dir), .rxcmd_valid(rxcmd_valid),
    .rx_active(rx_active), .tx_go(tx_go), .st(st), .spd_q(spd_q),
    .tx_allow(tx_allow), .resp_timeout(resp_timeout), .window_miss(window_miss)
);

// File: tb/ulpi_gap_ctrl_tb.sv
module ulpi_gap_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed = 2'b00;
    logic       host_role = 1'b0;
    logic       dir = 1'b0;
    logic       stp = 1'b0;
    logic       tx_go = 1'b0;
    logic       send_req = 1'b0;
    logic       rxcmd_valid = 1'b0;
    logic [1:0] rx_linestate = 2'b11;
    logic       rx_active = 1'b0;
    logic       tx_allow, resp_timeout, window_miss;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_gap_ctrl u_dut (
        .clk(clk), .rst(rst), .speed(speed), .host_role(host_role), .dir(dir),
        .stp(stp), .tx_go(tx_go), .send_req(send_req), .rxcmd_valid(rxcmd_valid),
        .rx_linestate(rx_linestate), .rx_active(rx_active),
        .tx_allow(tx_allow), .resp_timeout(resp_timeout), .window_miss(window_miss)
    );

    // kind: 0 tt_min, 1 tt_max, 2 rt_min, 3 rt_max, 4 timeout
    function automatic int lim(input int s, input int kind);
        int t[5];
        case (s)
            1:       t = '{7, 18, 7, 18, 80};
            2:       t = '{77, 247, 77, 247, 718};
            default: t = '{15, 24, 1, 14, 92};
        endcase
        return t[kind];
    endfunction

    function automatic logic is_hs(input int s);
        return (s != 1) && (s != 2);
    endfunction

    function automatic logic [1:0] jcode(input int s);
        return (s == 2) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp, input int j);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s j=%0d actual=%0b expected=%0b", tag, j, got, exp);
        end
    endtask

    task automatic step_clear;
        @(negedge clk);
        stp = 1'b0; tx_go = 1'b0; rxcmd_valid = 1'b0; rx_active = 1'b0; dir = 1'b0;
        #1;
    endtask

    task automatic start_tx;
        @(negedge clk); tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0;
    endtask

    task automatic trig_tx_end(input int s);
        @(negedge clk); stp = 1'b1;
        if (!is_hs(s)) begin
            @(negedge clk); stp = 1'b0; dir = 1'b1; rxcmd_valid = 1'b1; rx_linestate = 2'b00;
            @(negedge clk); rx_linestate = jcode(s);
        end
    endtask

    task automatic enter_rx(input int s);
        @(negedge clk); dir = 1'b1; rxcmd_valid = 1'b1; rx_active = 1'b1; rx_linestate = jcode(s);
        @(negedge clk); rxcmd_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic trig_rx_end(input int s);
        if (is_hs(s)) begin
            @(negedge clk); dir = 1'b0;
        end else begin
            @(negedge clk); rxcmd_valid = 1'b1; rx_active = 1'b0; rx_linestate = 2'b00;
            @(negedge clk); rx_linestate = jcode(s);
        end
    endtask

    task automatic tx_sweep(input int s, input logic host);
        int tmin = lim(s, 0), tmax = lim(s, 1), to = lim(s, 4);
        for (int j = 1; j <= to + 1; j++) begin
            step_clear();
            chk("R2/R6 tx_allow", tx_allow, (j == to + 1) ? 1'b1 : (host && j >= tmin && j <= tmax), j);
            chk("R6 resp_timeout", resp_timeout, j == to, j);
            chk("R8 window_miss", window_miss, host && send_req && j == tmax, j);
        end
    endtask

    task automatic rx_sweep(input int s);
        int rmin = lim(s, 2), rmax = lim(s, 3);
        for (int j = 1; j <= rmax + 1; j++) begin
            step_clear();
            chk("R4 tx_allow", tx_allow, (j > rmax) ? 1'b1 : (j >= rmin), j);
            chk("R8 window_miss", window_miss, send_req && j == rmax, j);
            chk("R4 resp_timeout", resp_timeout, 1'b0, j);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset tx_allow", tx_allow, 1'b1, 0);
        chk("R1 reset resp_timeout", resp_timeout, 1'b0, 0);
        chk("R1 reset window_miss", window_miss, 1'b0, 0);

        // Sweep every speed and role through both sequences (R2 R3 R4 R6 R8)
        for (int s = 0; s < 3; s++) begin
            for (int h = 0; h < 2; h++) begin
                speed = 2'(s); host_role = h[0]; send_req = 1'b1;
                start_tx();
                trig_tx_end(s);
                tx_sweep(s, h[0]);
                enter_rx(s);
                trig_rx_end(s);
                rx_sweep(s);
                send_req = 1'b0;
            end
        end

        // R9: code 11 behaves as high speed
        speed = 2'b11;
        enter_rx(3); trig_rx_end(3); rx_sweep(3);
        speed = 2'b00;

        // R4: high-speed end through receive command with rx_active low
        enter_rx(0);
        @(negedge clk); rxcmd_valid = 1'b1; rx_active = 1'b0;
        step_clear();
        chk("R4 rxcmd end opens window", tx_allow, 1'b1, 1);
        repeat (15) step_clear();
        chk("R4 back to idle", tx_allow, 1'b1, 16);

        // R5: second receive one cycle after the first ends
        enter_rx(0);
        @(negedge clk); dir = 1'b0;
        step_clear();
        chk("R5 first window", tx_allow, 1'b1, 1);
        @(negedge clk); dir = 1'b1; rxcmd_valid = 1'b1; rx_active = 1'b1;
        @(negedge clk); rxcmd_valid = 1'b0; #1;
        chk("R5 second rx accepted", tx_allow, 1'b0, 2);
        repeat (20) @(negedge clk);
        #1;
        chk("R5 gate held in rx", tx_allow, 1'b0, 22);
        @(negedge clk); dir = 1'b0;
        step_clear();
        chk("R5 window after second rx", tx_allow, 1'b1, 1);
        repeat (15) step_clear();

        // R7: response cancels timeout
        speed = 2'b00; host_role = 1'b0;
        start_tx(); trig_tx_end(0);
        for (int j = 1; j <= 30; j++) step_clear();
        @(negedge clk); dir = 1'b1; rxcmd_valid = 1'b1; rx_active = 1'b1;
        for (int j = 31; j <= 100; j++) begin
            @(negedge clk); rxcmd_valid = 1'b0; #1;
            chk("R7 no timeout", resp_timeout, 1'b0, j);
            chk("R7 gate closed", tx_allow, 1'b0, j);
        end
        @(negedge clk); dir = 1'b0;
        repeat (16) step_clear();
        chk("R7 idle after rx", tx_allow, 1'b1, 16);

        // R9: speed change mid-window has no effect
        speed = 2'b00;
        enter_rx(0);
        @(negedge clk); dir = 1'b0;
        for (int j = 1; j <= 15; j++) begin
            step_clear();
            if (j == 1) speed = 2'b10;
            chk("R9 window keeps latched speed", tx_allow, 1'b1, j);
        end
        speed = 2'b00;
        repeat (2) step_clear();

        // R3: low speed ignores the full-speed J code
        speed = 2'b10; host_role = 1'b0;
        start_tx();
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0; dir = 1'b1; rxcmd_valid = 1'b1; rx_linestate = 2'b00;
        @(negedge clk); rx_linestate = 2'b01;
        for (int j = 1; j <= 10; j++) begin
            step_clear();
            chk("R3 wrong J no start", tx_allow, 1'b0, j);
        end
        for (int j = 1; j <= 800; j++) begin
            step_clear();
            if (resp_timeout) begin
                n_chk++; n_err++;
                $display("FAIL R3 count started without LS J actual=1 expected=0");
            end
        end
        @(negedge clk); dir = 1'b1; rxcmd_valid = 1'b1; rx_linestate = 2'b00;
        @(negedge clk); rx_linestate = 2'b10;
        tx_sweep(2, 1'b0);
        speed = 2'b00;

        // R10: tx_go inside a receive window closes the gate
        enter_rx(0);
        @(negedge clk); dir = 1'b0;
        step_clear();
        chk("R10 window open", tx_allow, 1'b1, 1);
        @(negedge clk); tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0; #1;
        chk("R10 gate closed after go", tx_allow, 1'b0, 3);
        repeat (5) @(negedge clk);
        #1;
        chk("R10 gate closed during tx", tx_allow, 1'b0, 8);
        @(negedge clk); stp = 1'b1;
        repeat (93) step_clear();
        chk("R10 idle after timeout", tx_allow, 1'b1, 93);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule